// File: doc/BRIEF.md
# Pen-Down Poll Trigger Sequencer

This block turns a level-sensitive pen-down line from a resistive touch controller into a paced stream of single-cycle scan requests for a separate scan engine. After the first pen-down event it keeps asking for scans at a fixed interval. It keeps polling for a bounded number of periods after the pen lifts, then falls back to an idle state where only a fresh pen-down restarts activity. The pen line is masked while a scan is being requested or performed, because changing converter channels disturbs that line.

Timing is counted in microseconds. A prescaler divides the system clock into microsecond ticks. When the scan engine reports completion, the wait before the next poll step is shortened by the reported scan duration, so that polls stay close to the nominal interval. The pen line passes through a two-flop synchroniser before the sequencer uses it. Deasserting the enable stops everything and masks the pen line.

Top module: `pen_poll_trigger`

## Requirements
- R1: During and after reset, with enable low, `pen_mask_o` is 1 and `scan_trig_o` stays 0 whatever `pen_irq_i` does.
- R2: When `enable_i` is high and the block is off, `pen_mask_o` drops to 0 one clock edge later (idle, listening).
- R3: With the pen line unmasked, a high `pen_irq_i` produces a one-cycle `scan_trig_o` three edges after it rises (two synchroniser flops plus the sequencer register), and `pen_mask_o` is 1 while the trigger is high.
- R4: After a trigger, a `scan_done_i` pulse arms a wait of INTERVAL_US minus `scan_dur_us_i` microseconds. When it expires an idle poll of INTERVAL_US follows, and the next trigger comes ((2*INTERVAL_US - dur) * CLK_PER_US + 3) edges after the done pulse.
- R5: When `scan_dur_us_i` is at least INTERVAL_US, the wait after a done pulse is zero, and the next trigger comes INTERVAL_US * CLK_PER_US + 3 edges after the done pulse.
- R6: Poll steps that raise the poll count to a value below MIN_POLLS keep the pen line masked. Steps that raise it to MIN_POLLS or above unmask it during the idle poll, (INTERVAL_US - dur) * CLK_PER_US + 2 edges after the done pulse, and mask it again when that poll fires its trigger.
- R7: Once the poll count has reached MIN_POLLS + EXTRA_POLLS, the next expiry after a done pulse enters idle with the pen line unmasked, and no further trigger occurs without a new pen event.
- R8: A pen event during an unmasked poll window fires a trigger at once, clears the poll count to zero and cancels the pending poll timer, so no trigger follows until the next done pulse.
- R9: Dropping `enable_i` masks the pen line and cancels the timer one edge later. While off, no trigger is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pen_irq_i | input | 1 | Asynchronous pen-down level, high while touched |
| enable_i | input | 1 | Run enable; low forces the off state |
| scan_done_i | input | 1 | One-cycle pulse from the scan engine when a requested scan finishes |
| scan_dur_us_i | input | CNT_W | Duration of the finished scan in microseconds |
| scan_trig_o | output | 1 | One-cycle scan request |
| pen_mask_o | output | 1 | 1 while the pen line is ignored |

## Verification
A pen rise is due as a trigger after exactly three edges. A mask change caused by enable is due after one edge. After a done pulse, the mask opens after (INTERVAL_US - dur) * CLK_PER_US + 2 edges and the trigger comes after (2*INTERVAL_US - dur) * CLK_PER_US + 3 edges. The bench drives every stimulus on a falling edge and then counts rising edges, sampling on each following falling edge. It records the first edge at which the mask opens and the first at which a trigger appears, and compares those counts with the formulas above. Quiet periods (off, cancelled timer, idle after the last poll) are checked by watching the trigger over a window longer than two full intervals.

// File: rtl/pen_poll_pkg.sv
package pen_poll_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,  // disabled, pen masked
        ST_IDLE        = 3'd1,  // listening for pen, no timer
        ST_SCAN        = 3'd2,  // trigger issued, waiting for scan/timer
        ST_WAIT_MASKED = 3'd3,  // idle poll, pen masked
        ST_WAIT_OPEN   = 3'd4   // idle poll, pen listened to
    } poll_state_e;

    // Timer command from the sequencer
    typedef struct packed {
        logic start;
        logic stop;
    } tmr_cmd_t;

    // Remaining wait after a scan: interval minus duration, floored at zero
    function automatic logic [31:0] rearm_gap(input logic [31:0] ivl,
                                              input logic [31:0] dur);
        return (dur >= ivl) ? 32'd0 : (ivl - dur);
    endfunction

    // Pen line is listened to only in these states
    function automatic logic pen_open(input poll_state_e s);
        return (s == ST_IDLE) || (s == ST_WAIT_OPEN);
    endfunction

endpackage

// File: rtl/pen_sync.sv
module pen_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    generate
        if (STAGES < 2) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= async_i;
            end
            assign sync_o = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= {q[STAGES-2:0], async_i};
            end
            assign sync_o = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/us_timer.sv
module us_timer #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned CLK_PER_US = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] load_us_i,
    output logic             armed_o,
    output logic             expire_o
);
    localparam int unsigned PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            exp_q   <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (stop_i) begin
                armed_q <= 1'b0;
            end else if (start_i) begin
                pre_q <= '0;
                cnt_q <= load_us_i;
                if (load_us_i == '0) begin
                    armed_q <= 1'b0;
                    exp_q   <= 1'b1;
                end else begin
                    armed_q <= 1'b1;
                end
            end else if (armed_q) begin
                if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        armed_q <= 1'b0;
                        exp_q   <= 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    assign armed_o  = armed_q;
    assign expire_o = exp_q;
endmodule

// File: rtl/pen_poll_fsm.sv
module pen_poll_fsm
    import pen_poll_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned INTERVAL_US = 10000,
    parameter int unsigned MIN_POLLS   = 3,
    parameter int unsigned EXTRA_POLLS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             pen_i,
    input  logic             scan_done_i,
    input  logic [CNT_W-1:0] scan_dur_i,
    input  logic             expire_i,
    output tmr_cmd_t         tmr_cmd_o,
    output logic [CNT_W-1:0] tmr_load_o,
    output logic             trig_o,
    output logic             mask_o
);
    localparam int unsigned MAX_POLLS = MIN_POLLS + EXTRA_POLLS;
    localparam int unsigned PC_W      = $clog2(MAX_POLLS + 1);
    localparam logic [PC_W-1:0]  PC_MAX = PC_W'(MAX_POLLS);
    localparam logic [PC_W-1:0]  PC_MIN = PC_W'(MIN_POLLS);
    localparam logic [CNT_W-1:0] IVL    = CNT_W'(INTERVAL_US);

    poll_state_e      st_q, st_d;
    logic             mask_q, mask_d;
    logic             trig_q, trig_d;
    logic [PC_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic [CNT_W-1:0] gap;
    logic             pen_evt;

    assign cnt_inc = cnt_q + 1'b1;
    assign gap     = CNT_W'(rearm_gap(32'(IVL), 32'(scan_dur_i)));
    assign pen_evt = pen_i && !mask_q && pen_open(st_q);

    always_comb begin
        st_d       = st_q;
        mask_d     = mask_q;
        trig_d     = 1'b0;
        cnt_d      = cnt_q;
        tmr_cmd_o  = '0;
        tmr_load_o = '0;
        if (!enable_i) begin
            st_d           = ST_OFF;
            mask_d         = 1'b1;
            tmr_cmd_o.stop = 1'b1;
        end else if (st_q == ST_OFF) begin
            st_d   = ST_IDLE;
            mask_d = 1'b0;
        end else if (pen_evt) begin
            st_d           = ST_SCAN;
            mask_d         = 1'b1;
            trig_d         = 1'b1;
            cnt_d          = '0;
            tmr_cmd_o.stop = 1'b1;
        end else if (scan_done_i && st_q == ST_SCAN) begin
            tmr_cmd_o.start = 1'b1;
            tmr_load_o      = gap;
        end else if (expire_i) begin
            unique case (st_q)
                ST_SCAN: begin
                    if (cnt_q < PC_MAX) begin
                        cnt_d           = cnt_inc;
                        tmr_cmd_o.start = 1'b1;
                        tmr_load_o      = IVL;
                        if (cnt_inc >= PC_MIN) begin
                            st_d   = ST_WAIT_OPEN;
                            mask_d = 1'b0;
                        end else begin
                            st_d = ST_WAIT_MASKED;
                        end
                    end else begin
                        st_d   = ST_IDLE;
                        mask_d = 1'b0;
                    end
                end
                ST_WAIT_OPEN, ST_WAIT_MASKED: begin
                    st_d   = ST_SCAN;
                    mask_d = 1'b1;
                    trig_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OFF;
            mask_q <= 1'b1;
            trig_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
            trig_q <= trig_d;
            cnt_q  <= cnt_d;
        end
    end

    assign trig_o = trig_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/pen_poll_trigger.sv
module pen_poll_trigger
    import pen_poll_pkg::*;
#(
    parameter int unsigned CLK_PER_US  = 125,
    parameter int unsigned INTERVAL_US = 10000,
    parameter int unsigned MIN_POLLS   = 3,
    parameter int unsigned EXTRA_POLLS = 3,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pen_irq_i,
    input  logic             enable_i,
    input  logic             scan_done_i,
    input  logic [CNT_W-1:0] scan_dur_us_i,
    output logic             scan_trig_o,
    output logic             pen_mask_o
);
    logic             pen_s;
    tmr_cmd_t         tmr_cmd;
    logic [CNT_W-1:0] tmr_load;
    logic             tmr_armed;
    logic             tmr_exp;

    pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pen_irq_i),
        .sync_o  (pen_s)
    );

    us_timer #(.CNT_W(CNT_W), .CLK_PER_US(CLK_PER_US)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (tmr_cmd.start),
        .stop_i    (tmr_cmd.stop),
        .load_us_i (tmr_load),
        .armed_o   (tmr_armed),
        .expire_o  (tmr_exp)
    );

    pen_poll_fsm #(
        .CNT_W       (CNT_W),
        .INTERVAL_US (INTERVAL_US),
        .MIN_POLLS   (MIN_POLLS),
        .EXTRA_POLLS (EXTRA_POLLS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .pen_i       (pen_s),
        .scan_done_i (scan_done_i),
        .scan_dur_i  (scan_dur_us_i),
        .expire_i    (tmr_exp),
        .tmr_cmd_o   (tmr_cmd),
        .tmr_load_o  (tmr_load),
        .trig_o      (scan_trig_o),
        .mask_o      (pen_mask_o)
    );
endmodule

// File: rtl/pen_poll_checks.sv
module pen_poll_checks (
    input logic clk,
    input logic rst,
    input logic enable_i,
    input logic scan_trig_o,
    input logic pen_mask_o,
    input logic tmr_armed
);
    p_reset_mask_r1: assert property (@(posedge clk)
        rst |=> pen_mask_o);

    p_wake_open_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(enable_i)) |=> !pen_mask_o);

    p_trig_masked_r3: assert property (@(posedge clk) disable iff (rst)
        scan_trig_o |-> pen_mask_o);

    p_trig_single_r3: assert property (@(posedge clk) disable iff (rst)
        scan_trig_o |=> !scan_trig_o);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (pen_mask_o && !scan_trig_o && !tmr_armed));
endmodule

bind pen_poll_trigger pen_poll_checks chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable_i    (enable_i),
    .scan_trig_o (scan_trig_o),
    .pen_mask_o  (pen_mask_o),
    .tmr_armed   (tmr_armed)
);

// File: tb/pen_poll_trigger_tb_top.sv
module pen_poll_trigger_tb_top;
    localparam int CPU   = 4;
    localparam int IVL   = 20;
    localparam int CW    = 16;
    localparam int DUR   = 5;
    localparam int T_OPEN = (IVL - DUR) * CPU + 2;
    localparam int T_TRIG = (2 * IVL - DUR) * CPU + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pen = 1'b0;
    logic en = 1'b0;
    logic done = 1'b0;
    logic [CW-1:0] dur = CW'(DUR);
    logic trig, mask;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pen_poll_trigger #(
        .CLK_PER_US(CPU), .INTERVAL_US(IVL), .MIN_POLLS(3),
        .EXTRA_POLLS(3), .CNT_W(CW), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .pen_irq_i(pen), .enable_i(en),
        .scan_done_i(done), .scan_dur_us_i(dur),
        .scan_trig_o(trig), .pen_mask_o(mask)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    // count edges with no trigger; returns number of triggers seen
    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (trig) seen++;
        end
    endtask

    task automatic pen_hit(input bit keep, output int t);
        t = 0;
        pen = 1'b1;
        for (int n = 1; n <= 10; n++) begin
            @(posedge clk); @(negedge clk);
            if (trig) begin t = n; break; end
        end
        if (!keep) pen = 1'b0;
    endtask

    task automatic run_poll(input int limit, output int t_trig, output int t_open);
        t_trig = 0; t_open = 0;
        done = 1'b1;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk); @(negedge clk);
            done = 1'b0;
            if (t_open == 0 && !mask) t_open = n;
            if (trig) begin t_trig = n; break; end
        end
    endtask

    task automatic t_reset;
        int s;
        @(negedge clk);
        chk(mask == 1'b1, "R1 mask in reset", mask, 1);
        chk(trig == 1'b0, "R1 trig in reset", trig, 0);
        edges(2);
        rst = 1'b0;
        pen = 1'b1;
        quiet(12, s);
        chk(s == 0, "R1 no trig while off", s, 0);
        chk(mask == 1'b1, "R1 mask while off", mask, 1);
        pen = 1'b0;
        edges(4);
    endtask

    task automatic t_enable;
        en = 1'b1;
        edges(1);
        chk(mask == 1'b0, "R2 unmask one edge after enable", mask, 0);
    endtask

    task automatic t_pen_and_decay;
        int t, tt, to;
        pen_hit(1'b0, t);
        chk(t == 3, "R3 trigger latency", t, 3);
        chk(mask == 1'b1, "R3 masked with trigger", mask, 1);
        edges(1);
        chk(trig == 1'b0, "R3 single-cycle trigger", trig, 0);
        for (int p = 1; p <= 6; p++) begin
            run_poll(400, tt, to);
            chk(tt == T_TRIG, "R4 poll trigger spacing", tt, T_TRIG);
            if (p < 3) chk(to == 0, "R6 early poll stays masked", to, 0);
            else       chk(to == T_OPEN, "R6 late poll opens pen line", to, T_OPEN);
        end
        run_poll(400, tt, to);
        chk(tt == 0, "R7 no trigger after last poll", tt, 0);
        chk(to == T_OPEN, "R7 idle unmask timing", to, T_OPEN);
        chk(mask == 1'b0, "R7 idle unmasked", mask, 0);
    endtask

    task automatic t_long_scan;
        int t, tt, to;
        pen_hit(1'b0, t);
        chk(t == 3, "R7 pen restarts from idle", t, 3);
        dur = CW'(IVL + 10);
        run_poll(400, tt, to);
        chk(tt == IVL * CPU + 3, "R5 zero wait when scan too long", tt, IVL * CPU + 3);
        chk(to == 0, "R5 first poll masked", to, 0);
        dur = CW'(DUR);
    endtask

    task automatic t_pen_in_window;
        int tt, to, s;
        pen = 1'b1;
        run_poll(400, tt, to);
        chk(tt == T_TRIG, "R8 setup poll", tt, T_TRIG);
        run_poll(400, tt, to);
        chk(to == T_OPEN, "R8 window opens", to, T_OPEN);
        chk(tt == T_OPEN + 1, "R8 pen event fires in window", tt, T_OPEN + 1);
        pen = 1'b0;
        quiet(2 * IVL * CPU + 20, s);
        chk(s == 0, "R8 pending timer cancelled", s, 0);
        run_poll(400, tt, to);
        chk(to == 0, "R8 count cleared keeps mask", to, 0);
        chk(tt == T_TRIG, "R8 polling resumes", tt, T_TRIG);
    endtask

    task automatic t_disable;
        int tt, to, s;
        run_poll(400, tt, to);
        chk(tt == T_TRIG, "R9 setup poll", tt, T_TRIG);
        done = 1'b1;
        edges(1);
        done = 1'b0;
        edges(T_OPEN + 5);
        chk(mask == 1'b0, "R9 window open before disable", mask, 0);
        en = 1'b0;
        edges(1);
        chk(mask == 1'b1, "R9 masked one edge after disable", mask, 1);
        pen = 1'b1;
        quiet(2 * IVL * CPU + 20, s);
        chk(s == 0, "R9 no trigger while off", s, 0);
        en = 1'b1;
        edges(1);
        chk(mask == 1'b0, "R2 re-enable unmasks", mask, 0);
        edges(1);
        chk(trig == 1'b1, "R3 held pen fires after re-enable", trig, 1);
        pen = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_pen_and_decay();
        t_long_scan();
        t_pen_in_window();
        t_disable();
        edges(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule